// File: doc/BRIEF.md
# Split-Array SAR Switching Controller

This block sequences a 10-bit differential successive-approximation conversion on a split capacitor array. Each of the two sides, P and N, has an upper-weight sub-array and a lower-weight sub-array. Each sub-array holds binary-weighted plates plus one unit dummy plate. A conversion request starts one acquisition cycle, in which the input is held on the top plates. Ten comparator decisions follow, one per clock. After each decision the block registers a new reference choice for every bottom plate. The choices are ground, mid reference, full reference or quarter reference.

The first decision needs no plate movement. The second step splits the array: the side judged higher drops its lower sub-array to mid reference, and the side judged lower raises its upper sub-array to mid reference. Each middle step then moves one matched pair of plates of equal weight, one plate on each side, in opposite directions. The sign of the first decision sets which references the two sides use. The latest decision sets which pair moves. The two final steps each move a single dummy plate. The first of them moves a full mid-reference step. The second moves a quarter-reference half step, on the other side. The common mode therefore stays fixed until the dummy steps.

The block also drives the acquisition strobe, a thermometer of completed switching steps, the offset-binary result and a one-cycle done flag.

Top module: `sar_split_ctrl`

## Requirements
- R1: After a synchronous reset, acq, done, step_therm and result are all zero. Every upper-sub-array select reads 00 (ground) and every lower-sub-array select reads 10 (full reference). A reset during a conversion returns the block to this state at the next clock edge.
- R2: A conv_req sampled high while idle raises acq for exactly the next cycle. Ten decision cycles follow. done is high for one cycle, 11 clock edges after the edge that sampled conv_req.
- R3: result is offset binary, with the first decision in bit 9 and the last in bit 0. With an ideal comparator it equals the ideal binary-search code for every input.
- R4: The first decision is taken while all plates still hold the acquisition pattern. The first switching step then moves all 14 plates. The lower sub-array of the side judged higher goes 10 to 01, and the upper sub-array of the other side goes 00 to 01. This shifts the differential voltage by half the reference, opposite to the decision.
- R5: Switching steps 2 to 7 each move exactly two plates of weight 2^(7-s), where s is the step number. Decision 1 (P above N) lowers P's lower-sub-array plate one level and raises N's upper-sub-array plate one level. Decision 0 raises P's upper-sub-array plate and lowers N's lower-sub-array plate. Each step halves the differential change of the previous one.
- R6: Step 8 moves only one dummy plate: on N if the first decision was 1, on P otherwise. If the first decision equals the latest one, the upper-sub-array dummy goes 01 to 10. Otherwise the lower-sub-array dummy goes 10 to 01.
- R7: Step 9 moves only one dummy plate, on the side that step 8 left alone. If the first decision equals the latest one, the lower-sub-array dummy goes 01 to 11. Otherwise the upper-sub-array dummy goes 00 to 11. The differential change is half that of step 8.
- R8: Select code 11 (quarter reference) never appears on a non-dummy plate. It appears on exactly one dummy plate only after step 9.
- R9: step_therm bit i-1 rises at switching step i and stays high to the end of the conversion, so step_therm is always a thermometer code. It is all ones while done is high.
- R10: On the clock edge after done, all selects return to the acquisition pattern and step_therm clears.
- R11: conv_req is ignored while a conversion is in progress. Timing and result are unchanged, and no new acquisition starts afterwards.
- R12: Through switching step 7, the weighted sum of all plate references over both sides stays equal to its acquisition value (constant common mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_req | input | 1 | Conversion request, acted on only when idle |
| cmp_hi | input | 1 | Comparator decision, 1 when P is above N |
| acq | output | 1 | High during the acquisition cycle |
| step_therm | output | 9 | Thermometer of completed switching steps |
| p_msb_sel | output | 14 | P upper sub-array selects, 2 bits per plate, plate 0 is the dummy |
| p_lsb_sel | output | 14 | P lower sub-array selects |
| n_msb_sel | output | 14 | N upper sub-array selects |
| n_lsb_sel | output | 14 | N lower sub-array selects |
| result | output | 10 | Conversion result, held until the next done |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
The hardest cases are the two final dummy steps. Which plate moves, on which side and to which reference depends on both the first decision and the latest one. Only input codes near particular sub-ranges reach each of the four combinations. The bench closes the loop through an ideal differential charge model of the array, so the comparator input follows the selects. It then sweeps all 1024 input codes, which drives every combination of first and latest decision into both dummy steps. At every step it checks the size and sign of the voltage change, the plates moved on each side, and the common mode.

// File: rtl/sar_split_pkg.sv
package sar_split_pkg;

  typedef enum logic [1:0] {
    LVL_GND  = 2'b00,
    LVL_VCM  = 2'b01,
    LVL_VREF = 2'b10,
    LVL_QTR  = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_SPLIT,
    OP_PAIR,
    OP_DUMMY_FINE,
    OP_DUMMY_QTR
  } op_e;

  function automatic logic [1:0] lvl_up(input logic [1:0] cur);
    case (cur)
      LVL_GND: return LVL_VCM;
      LVL_VCM: return LVL_VREF;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] lvl_down(input logic [1:0] cur);
    case (cur)
      LVL_VREF: return LVL_VCM;
      LVL_VCM:  return LVL_GND;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/sar_split_seq.sv
module sar_split_seq
  import sar_split_pkg::*;
#(
  parameter int NBITS = 10,
  localparam int NP = NBITS - 3,
  localparam int KW = $clog2(NBITS),
  localparam int IW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             cmp_hi,
  output logic             acq,
  output logic             done,
  output logic [NBITS-2:0] step_therm,
  output logic [NBITS-1:0] result,
  output op_e              op,
  output logic [IW-1:0]    idx,
  output logic             msb_now,
  output logic             restore
);

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV, S_FIN} st_e;

  st_e             state;
  logic [KW-1:0]   k;
  logic            msb_q;
  logic [NBITS-2:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      k          <= '0;
      msb_q      <= 1'b0;
      bits_q     <= '0;
      result     <= '0;
      done       <= 1'b0;
      acq        <= 1'b0;
      step_therm <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (conv_req) begin
          state <= S_ACQ;
          acq   <= 1'b1;
        end
        S_ACQ: begin
          acq        <= 1'b0;
          state      <= S_CONV;
          k          <= '0;
          step_therm <= '0;
        end
        S_CONV: begin
          bits_q <= {bits_q[NBITS-3:0], cmp_hi};
          if (k == '0) msb_q <= cmp_hi;
          if (k == KW'(NBITS - 1)) begin
            state  <= S_FIN;
            done   <= 1'b1;
            result <= {bits_q, cmp_hi};
          end else begin
            step_therm <= {step_therm[NBITS-3:0], 1'b1};
            k          <= k + 1'b1;
          end
        end
        default: begin
          state      <= S_IDLE;
          step_therm <= '0;
        end
      endcase
    end
  end

  always_comb begin
    op  = OP_HOLD;
    idx = '0;
    if (state == S_CONV) begin
      if (k == '0) begin
        op = OP_SPLIT;
      end else if (k <= KW'(NBITS - 4)) begin
        op  = OP_PAIR;
        idx = IW'(NP) - IW'(k);
      end else if (k == KW'(NBITS - 3)) begin
        op = OP_DUMMY_FINE;
      end else if (k == KW'(NBITS - 2)) begin
        op = OP_DUMMY_QTR;
      end
    end
  end

  assign msb_now = (k == '0) ? cmp_hi : msb_q;
  assign restore = (state == S_FIN);

endmodule

// File: rtl/sar_plate_bank.sv
module sar_plate_bank
  import sar_split_pkg::*;
#(
  parameter int NP   = 7,
  parameter bit IS_P = 1'b1,
  localparam int IW  = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restore,
  input  op_e           op,
  input  logic [IW-1:0] idx,
  input  logic          msb_now,
  input  logic          dec,
  output logic [2*NP-1:0] sel_m,
  output logic [2*NP-1:0] sel_l
);

  logic is_hi;
  logic same;
  assign is_hi = IS_P ? msb_now : ~msb_now;
  assign same  = (msb_now == dec);

  for (genvar j = 0; j < NP; j++) begin : g_plate
    logic [1:0] m_r;
    logic [1:0] l_r;

    always_ff @(posedge clk) begin
      if (rst || restore) begin
        m_r <= LVL_GND;
        l_r <= LVL_VREF;
      end else begin
        case (op)
          OP_SPLIT: begin
            if (is_hi) l_r <= LVL_VCM;
            else       m_r <= LVL_VCM;
          end
          OP_PAIR: begin
            if (idx == IW'(j)) begin
              if (dec == IS_P) l_r <= lvl_down(l_r);
              else             m_r <= lvl_up(m_r);
            end
          end
          OP_DUMMY_FINE: begin
            if (j == 0 && !is_hi) begin
              if (same) m_r <= LVL_VREF;
              else      l_r <= LVL_VCM;
            end
          end
          OP_DUMMY_QTR: begin
            if (j == 0 && is_hi) begin
              if (same) l_r <= LVL_QTR;
              else      m_r <= LVL_QTR;
            end
          end
          default: ;
        endcase
      end
    end

    assign sel_m[2*j +: 2] = m_r;
    assign sel_l[2*j +: 2] = l_r;
  end

endmodule

// File: rtl/sar_split_ctrl.sv
module sar_split_ctrl
  import sar_split_pkg::*;
#(
  parameter int NBITS = 10,
  localparam int NP = NBITS - 3,
  localparam int IW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_req,
  input  logic             cmp_hi,
  output logic             acq,
  output logic [NBITS-2:0] step_therm,
  output logic [2*NP-1:0]  p_msb_sel,
  output logic [2*NP-1:0]  p_lsb_sel,
  output logic [2*NP-1:0]  n_msb_sel,
  output logic [2*NP-1:0]  n_lsb_sel,
  output logic [NBITS-1:0] result,
  output logic             done
);

  op_e           op;
  logic [IW-1:0] idx;
  logic          msb_now;
  logic          restore;

  sar_split_seq #(.NBITS(NBITS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .conv_req   (conv_req),
    .cmp_hi     (cmp_hi),
    .acq        (acq),
    .done       (done),
    .step_therm (step_therm),
    .result     (result),
    .op         (op),
    .idx        (idx),
    .msb_now    (msb_now),
    .restore    (restore)
  );

  sar_plate_bank #(.NP(NP), .IS_P(1'b1)) u_bank_p (
    .clk     (clk),
    .rst     (rst),
    .restore (restore),
    .op      (op),
    .idx     (idx),
    .msb_now (msb_now),
    .dec     (cmp_hi),
    .sel_m   (p_msb_sel),
    .sel_l   (p_lsb_sel)
  );

  sar_plate_bank #(.NP(NP), .IS_P(1'b0)) u_bank_n (
    .clk     (clk),
    .rst     (rst),
    .restore (restore),
    .op      (op),
    .idx     (idx),
    .msb_now (msb_now),
    .dec     (cmp_hi),
    .sel_m   (n_msb_sel),
    .sel_l   (n_lsb_sel)
  );

endmodule

// File: rtl/sar_split_ctrl_chk.sv
module sar_split_ctrl_chk #(
  parameter int NBITS = 10,
  localparam int NP = NBITS - 3
) (
  input logic             clk,
  input logic             rst,
  input logic             acq,
  input logic             done,
  input logic [NBITS-2:0] step_therm,
  input logic [2*NP-1:0]  p_msb_sel,
  input logic [2*NP-1:0]  p_lsb_sel,
  input logic [2*NP-1:0]  n_msb_sel,
  input logic [2*NP-1:0]  n_lsb_sel
);

  logic at_rest;
  logic qtr_bad;

  always_comb begin
    at_rest = 1'b1;
    qtr_bad = 1'b0;
    for (int j = 0; j < NP; j++) begin
      if (p_msb_sel[2*j +: 2] != 2'b00 || n_msb_sel[2*j +: 2] != 2'b00 ||
          p_lsb_sel[2*j +: 2] != 2'b10 || n_lsb_sel[2*j +: 2] != 2'b10)
        at_rest = 1'b0;
      if (j > 0 && (p_msb_sel[2*j +: 2] == 2'b11 || n_msb_sel[2*j +: 2] == 2'b11 ||
                    p_lsb_sel[2*j +: 2] == 2'b11 || n_lsb_sel[2*j +: 2] == 2'b11))
        qtr_bad = 1'b1;
    end
  end

  AST_QTR_DUMMY_ONLY: assert property (@(posedge clk) disable iff (rst) !qtr_bad); // R8
  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (step_therm & (step_therm + 1'b1)) == '0); // R9
  AST_THERM_FULL_AT_DONE: assert property (@(posedge clk) disable iff (rst) done |-> &step_therm); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R2
  AST_ACQ_SINGLE: assert property (@(posedge clk) disable iff (rst) acq |=> !acq); // R2
  AST_ACQ_PATTERN: assert property (@(posedge clk) disable iff (rst) acq |-> at_rest); // R4
  AST_RESTORE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> (at_rest && step_therm == '0)); // R10

endmodule

bind sar_split_ctrl sar_split_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acq        (acq),
  .done       (done),
  .step_therm (step_therm),
  .p_msb_sel  (p_msb_sel),
  .p_lsb_sel  (p_lsb_sel),
  .n_msb_sel  (n_msb_sel),
  .n_lsb_sel  (n_lsb_sel)
);

// File: tb/sar_split_ctrl_test.sv
module sar_split_ctrl_test;

  localparam int NBITS = 10;
  localparam int NP    = NBITS - 3;
  localparam int FS    = 1 << NBITS;
  localparam logic [2*NP-1:0] REST_M = '0;
  localparam logic [2*NP-1:0] REST_L = {NP{2'b10}};

  // code, conv_req hold start (0 = none), expected result
  localparam int NVEC = 12;
  localparam int TAB [NVEC][3] = '{
    '{0, 0, 0}, '{1023, 0, 1023}, '{511, 3, 511}, '{512, 0, 512},
    '{1, 0, 1}, '{1022, 2, 1022}, '{341, 0, 341}, '{682, 0, 682},
    '{256, 4, 256}, '{767, 0, 767}, '{85, 0, 85}, '{600, 5, 600}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             conv_req;
  logic             cmp_hi;
  logic             acq;
  logic [NBITS-2:0] step_therm;
  logic [2*NP-1:0]  p_msb_sel, p_lsb_sel, n_msb_sel, n_lsb_sel;
  logic [NBITS-1:0] result;
  logic             done;

  int code_in;
  int sp, sn, diffv, cmv;
  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sar_split_ctrl #(.NBITS(NBITS)) uut (
    .clk(clk), .rst(rst), .conv_req(conv_req), .cmp_hi(cmp_hi), .acq(acq),
    .step_therm(step_therm), .p_msb_sel(p_msb_sel), .p_lsb_sel(p_lsb_sel),
    .n_msb_sel(n_msb_sel), .n_lsb_sel(n_lsb_sel), .result(result), .done(done)
  );

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'b00:   return 0;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int psum(input logic [2*NP-1:0] s, input int base);
    int acc = 0;
    for (int j = 0; j < NP; j++) begin
      int w;
      w = (j == 0) ? 1 : (1 << (j - 1));
      acc += w * (lvl(s[2*j +: 2]) - base);
    end
    return acc;
  endfunction

  function automatic int nchg(input logic [2*NP-1:0] a, input logic [2*NP-1:0] b);
    int c = 0;
    for (int j = 0; j < NP; j++) if (a[2*j +: 2] != b[2*j +: 2]) c++;
    return c;
  endfunction

  function automatic int nqtr(input logic [2*NP-1:0] s);
    int c = 0;
    for (int j = 0; j < NP; j++) if (s[2*j +: 2] == 2'b11) c++;
    return c;
  endfunction

  // ideal differential array: units of VREF / 2^NBITS
  always_comb begin
    sp     = psum(p_msb_sel, 0) + psum(p_lsb_sel, 4);
    sn     = psum(n_msb_sel, 0) + psum(n_lsb_sel, 4);
    diffv  = (2 * code_in + 1 - FS) + 2 * (sp - sn);
    cmv    = sp + sn;
    cmp_hi = (diffv > 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit rest_ok();
    return p_msb_sel == REST_M && n_msb_sel == REST_M &&
           p_lsb_sel == REST_L && n_lsb_sel == REST_L;
  endfunction

  task automatic convert(input int x, input int busy_at, input int expv);
    logic [2*NP-1:0] q_pm, q_pl, q_nm, q_nl;
    int pdiff, dec, s, cp, cn, mag;
    bit msb;
    msb = (x >= FS / 2);
    @(negedge clk);
    code_in  = x;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    chk("R2 acq high after request", int'(acq), 1);
    for (int n = 1; n <= 12; n++) begin
      q_pm = p_msb_sel; q_pl = p_lsb_sel; q_nm = n_msb_sel; q_nl = n_lsb_sel;
      pdiff = diffv;
      dec   = int'(cmp_hi);
      conv_req = (busy_at > 0 && n >= busy_at && n <= busy_at + 2);
      @(negedge clk);
      s  = n - 1;
      cp = nchg(q_pm, p_msb_sel) + nchg(q_pl, p_lsb_sel);
      cn = nchg(q_nm, n_msb_sel) + nchg(q_nl, n_lsb_sel);
      if (n == 1) begin
        chk("R2 acq single cycle", int'(acq), 0);
        chk("R4 pattern at first decision", int'(rest_ok()), 1);
      end else if (n <= 10) begin
        mag = FS >> s;
        chk("R9 thermometer", int'(step_therm), (1 << s) - 1);
        chk("R2 no early done", int'(done), 0);
        chk("R8 quarter only after final step", nqtr(p_msb_sel) + nqtr(p_lsb_sel) +
            nqtr(n_msb_sel) + nqtr(n_lsb_sel), (s == 9) ? 1 : 0);
        if (s == 1) begin
          chk("R4 split step size/sign", pdiff - diffv, dec ? mag : -mag);
          chk("R4 split plate count", cp + cn, 2 * NP);
        end else if (s <= NBITS - 3) begin
          chk("R5 pair step size/sign", pdiff - diffv, dec ? mag : -mag);
          chk("R5 pair moves one plate per side", cp * 10 + cn, 11);
        end else if (s == NBITS - 2) begin
          chk("R6 dummy step size/sign", pdiff - diffv, dec ? mag : -mag);
          chk("R6 dummy side", cp * 10 + cn, msb ? 1 : 10);
        end else begin
          chk("R7 quarter step size/sign", pdiff - diffv, dec ? mag : -mag);
          chk("R7 quarter side", cp * 10 + cn, msb ? 10 : 1);
        end
        if (s <= NBITS - 3) chk("R12 common mode held", cmv, 0);
      end else if (n == 11) begin
        chk("R2 done pulse", int'(done), 1);
        chk("R3 result code", int'(result), expv);
        if (busy_at > 0) chk("R11 request ignored while busy", int'(result), expv);
      end else begin
        chk("R2 done one cycle", int'(done), 0);
        chk("R10 selects restored", int'(rest_ok()), 1);
        chk("R10 thermometer cleared", int'(step_therm), 0);
        chk("R11 no new acquisition", int'(acq), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    conv_req = 1'b0;
    code_in  = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset acq", int'(acq), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset thermometer", int'(step_therm), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset selects", int'(rest_ok()), 1);
    rst = 1'b0;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) convert(TAB[v][0], TAB[v][1], TAB[v][2]);

    // reset in the middle of a conversion
    code_in  = 700;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset selects", int'(rest_ok()), 1);
    chk("R1 mid reset thermometer", int'(step_therm), 0);
    chk("R1 mid reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(acq), 0);

    // exhaustive sweep
    for (int x = 0; x < FS; x++) convert(x, 0, x);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule